// File: doc/BRIEF.md
# Symbolic Rename Table Optimizer

This block sits beside the register alias table in the rename stage. For every architectural register it keeps a symbolic value: either a known constant, or an expression `(physical_reg << scale) + offset`. Each decoded simple ALU instruction is rewritten through these expressions. The rewrite moves the instruction's dependence back to the earliest producer and folds the immediates together. When all inputs are known, the block executes the instruction on the spot and records the constant result.

Execution units report results for physical registers on a feedback port. Every table entry built on that register then becomes a known constant. Rewriting never waits for feedback, so one instruction is accepted and one rewritten result is produced on every cycle. The allocator outside the block supplies the new physical register for each destination.

The outcome for each instruction takes one of three kinds:
- constant: executed at rename; `out_offset` carries the value.
- symbolic: the core computes `(out_base << out_scale) + out_offset`.
- plain: the instruction runs as decoded and writes `out_dst_preg`.

Top module: `symrt_core`

## Requirements
- R1: After reset, every architectural register i maps to physical register i with scale 0 and offset 0, is not known, and `out_valid` is 0.
- R2: Opcode encodings are: 0 move, 1 add-immediate, 2 add, 3 subtract, 4 scaled add, 5 load-immediate, 6 and 7 other. Kind encodings are: 0 plain, 1 symbolic, 2 constant. Load-immediate, and any add-immediate, add, subtract or legal scaled add whose inputs are all known, yields kind 2 with the computed value in `out_offset`. The destination is recorded as that constant.
- R3: An add-immediate, add or subtract with exactly one unknown operand (for subtract, only the minuend) yields kind 1. The result takes that operand's base and scale, and an offset equal to its offset combined with the known input.
- R4: A move copies its source's symbolic value, known or not, into the destination and reports it.
- R5: A scaled add `(A << in_shift) + B` is rewritten only for `in_shift` 2 or 3. With A unknown, A's scale must be 0, and the result then takes scale `in_shift`. A result scale above 3 falls back to plain. No output ever carries scale 1.
- R6: A plain outcome happens in these cases: an "other" op; an add with both operands unknown; a subtract with an unknown subtrahend; any rejected rewrite. A plain outcome maps the destination to `in_dst_preg` with scale 0 and offset 0, and reports that same mapping.
- R7: With `in_is32`=1, every constant and symbolic offset produced is sign-extended from bit 31, and the entry is marked 32-bit. A 64-bit instruction reading an unknown 32-bit entry falls back to plain.
- R8: Feedback `(fb_preg, fb_value)` turns every unknown entry whose base is `fb_preg` into the constant `(fb_value << scale) + offset`. That constant is sign-extended from bit 31 for a 32-bit entry. Entries on other bases are unchanged.
- R9: Feedback in the same cycle as an instruction is merged before that instruction reads the table.
- R10: Results appear exactly one cycle after `in_valid`, with `out_dst_preg` equal to the supplied register. `out_valid` is 0 in a cycle after no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 3 | Opcode (see R2) |
| in_is32 | input | 1 | 32-bit operation |
| in_src_a | input | 3 | First source architectural register |
| in_src_b | input | 3 | Second source architectural register |
| in_imm | input | 64 | Immediate for add-immediate and load-immediate |
| in_shift | input | 2 | Shift applied to the first operand of a scaled add |
| in_dst | input | 3 | Destination architectural register |
| in_dst_preg | input | 6 | Newly allocated physical register |
| fb_valid | input | 1 | Feedback present |
| fb_preg | input | 6 | Physical register whose value is reported |
| fb_value | input | 64 | Reported value |
| out_valid | output | 1 | Rewritten result present |
| out_kind | output | 2 | Outcome kind (see R2) |
| out_dst_preg | output | 6 | Destination physical register |
| out_base | output | 6 | Base physical register of the expression |
| out_scale | output | 2 | Left shift on the base |
| out_offset | output | 64 | Offset, or the value for kind 2 |
| out_w32 | output | 1 | Expression is 32-bit |

## Verification
Each rewritten result is registered once, so it is due on the rising edge after the one that accepted the instruction. The table update from that instruction is first visible to an instruction accepted on the next edge. Feedback takes effect on the same edge on which it is presented, and is visible to an instruction presented alongside it. The bench drives inputs on falling edges and reads every result on the falling edge after the accepting rising edge. Entries changed by feedback are read back with move instructions.

// File: rtl/sym_pkg.sv
package sym_pkg;

    localparam int SYM_PREG_W = 6;
    localparam int SYM_OFF_W  = 64;

    typedef enum logic [2:0] {
        OP_MOV   = 3'd0,
        OP_ADDI  = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_SADD  = 3'd4,
        OP_LDI   = 3'd5,
        OP_OTHER = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_SYMB  = 2'd1,
        K_CONST = 2'd2
    } kind_e;

    // one symbolic register value; when known, off holds the constant
    typedef struct packed {
        logic                  known;
        logic                  w32;
        logic [SYM_PREG_W-1:0] base;
        logic [1:0]            scale;
        logic [SYM_OFF_W-1:0]  off;
    } sym_ent_t;

    function automatic logic [SYM_OFF_W-1:0] sext32(input logic [SYM_OFF_W-1:0] v);
        sext32 = {{(SYM_OFF_W-32){v[31]}}, v[31:0]};
    endfunction

endpackage

// File: rtl/sym_fb_merge.sv
module sym_fb_merge
    import sym_pkg::*;
#(
    parameter int NUM_ARCH = 8
) (
    input  sym_ent_t [NUM_ARCH-1:0] tbl_i,
    input  logic                    fb_valid,
    input  logic [SYM_PREG_W-1:0]   fb_preg,
    input  logic [SYM_OFF_W-1:0]    fb_value,
    output sym_ent_t [NUM_ARCH-1:0] tbl_o
);

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
        logic [SYM_OFF_W-1:0] val;
        always_comb begin
            val      = (fb_value << tbl_i[g].scale) + tbl_i[g].off;
            tbl_o[g] = tbl_i[g];
            if (fb_valid && !tbl_i[g].known && (tbl_i[g].base == fb_preg)) begin
                tbl_o[g]       = '0;
                tbl_o[g].known = 1'b1;
                tbl_o[g].off   = tbl_i[g].w32 ? sext32(val) : val;
            end
        end
    end

endmodule

// File: rtl/sym_rewrite.sv
module sym_rewrite
    import sym_pkg::*;
(
    input  sym_ent_t              ea,
    input  sym_ent_t              eb,
    input  op_e                   op,
    input  logic                  is32,
    input  logic [SYM_OFF_W-1:0]  imm,
    input  logic [1:0]            shift,
    input  logic [SYM_PREG_W-1:0] dst_preg,
    output sym_ent_t              res,
    output kind_e                 kind
);

    function automatic sym_ent_t mk_const(input logic [SYM_OFF_W-1:0] v, input logic w);
        mk_const       = '0;
        mk_const.known = 1'b1;
        mk_const.off   = w ? sext32(v) : v;
    endfunction

    function automatic sym_ent_t mk_sym(input logic [SYM_PREG_W-1:0] b, input logic [1:0] s,
                                        input logic [SYM_OFF_W-1:0] o, input logic w);
        mk_sym       = '0;
        mk_sym.w32   = w;
        mk_sym.base  = b;
        mk_sym.scale = s;
        mk_sym.off   = w ? sext32(o) : o;
    endfunction

    logic                 use_a, use_b, sh_ok;
    logic [SYM_OFF_W-1:0] a_sh;

    always_comb begin
        // an unknown operand is usable unless a 64-bit op reads a 32-bit entry
        use_a = !ea.known && (!ea.w32 || is32);
        use_b = !eb.known && (!eb.w32 || is32);
        sh_ok = (shift == 2'd2) || (shift == 2'd3);
        a_sh  = ea.off << shift;
        res        = '0;
        res.base   = dst_preg;
        kind       = K_PLAIN;
        unique case (op)
            OP_LDI: begin
                res = mk_const(imm, is32); kind = K_CONST;
            end
            OP_MOV: begin
                if (ea.known) begin
                    res = mk_const(ea.off, is32); kind = K_CONST;
                end else if (use_a) begin
                    res = mk_sym(ea.base, ea.scale, ea.off, is32); kind = K_SYMB;
                end
            end
            OP_ADDI: begin
                if (ea.known) begin
                    res = mk_const(ea.off + imm, is32); kind = K_CONST;
                end else if (use_a) begin
                    res = mk_sym(ea.base, ea.scale, ea.off + imm, is32); kind = K_SYMB;
                end
            end
            OP_ADD: begin
                if (ea.known && eb.known) begin
                    res = mk_const(ea.off + eb.off, is32); kind = K_CONST;
                end else if (ea.known && use_b) begin
                    res = mk_sym(eb.base, eb.scale, ea.off + eb.off, is32); kind = K_SYMB;
                end else if (eb.known && use_a) begin
                    res = mk_sym(ea.base, ea.scale, ea.off + eb.off, is32); kind = K_SYMB;
                end
            end
            OP_SUB: begin
                if (ea.known && eb.known) begin
                    res = mk_const(ea.off - eb.off, is32); kind = K_CONST;
                end else if (eb.known && use_a) begin
                    res = mk_sym(ea.base, ea.scale, ea.off - eb.off, is32); kind = K_SYMB;
                end
            end
            OP_SADD: begin
                if (sh_ok) begin
                    if (ea.known && eb.known) begin
                        res = mk_const(a_sh + eb.off, is32); kind = K_CONST;
                    end else if (ea.known && use_b) begin
                        res = mk_sym(eb.base, eb.scale, a_sh + eb.off, is32); kind = K_SYMB;
                    end else if (eb.known && use_a && (ea.scale == 2'd0)) begin
                        res = mk_sym(ea.base, shift, a_sh + eb.off, is32); kind = K_SYMB;
                    end
                end
            end
            default: begin
                kind = K_PLAIN;
            end
        endcase
    end

endmodule

// File: rtl/symrt_core.sv
module symrt_core
    import sym_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    localparam int AW      = $clog2(NUM_ARCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic                  in_is32,
    input  logic [AW-1:0]         in_src_a,
    input  logic [AW-1:0]         in_src_b,
    input  logic [SYM_OFF_W-1:0]  in_imm,
    input  logic [1:0]            in_shift,
    input  logic [AW-1:0]         in_dst,
    input  logic [SYM_PREG_W-1:0] in_dst_preg,
    input  logic                  fb_valid,
    input  logic [SYM_PREG_W-1:0] fb_preg,
    input  logic [SYM_OFF_W-1:0]  fb_value,
    output logic                  out_valid,
    output logic [1:0]            out_kind,
    output logic [SYM_PREG_W-1:0] out_dst_preg,
    output logic [SYM_PREG_W-1:0] out_base,
    output logic [1:0]            out_scale,
    output logic [SYM_OFF_W-1:0]  out_offset,
    output logic                  out_w32
);

    typedef struct packed {
        logic                  vld;
        kind_e                 kind;
        logic [SYM_PREG_W-1:0] dst;
        logic [SYM_PREG_W-1:0] base;
        logic [1:0]            scale;
        logic [SYM_OFF_W-1:0]  off;
        logic                  w32;
    } res_t;

    typedef struct packed {
        sym_ent_t [NUM_ARCH-1:0] tbl;
        res_t                    o;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            s.tbl[i].base = SYM_PREG_W'(i);
        end
        return s;
    endfunction

    state_t                  st_d, st_q;
    sym_ent_t [NUM_ARCH-1:0] merged;
    sym_ent_t                rw_res;
    kind_e                   rw_kind;

    sym_fb_merge #(.NUM_ARCH(NUM_ARCH)) u_merge (
        .tbl_i    (st_q.tbl),
        .fb_valid (fb_valid),
        .fb_preg  (fb_preg),
        .fb_value (fb_value),
        .tbl_o    (merged)
    );

    sym_rewrite u_rewrite (
        .ea       (merged[in_src_a]),
        .eb       (merged[in_src_b]),
        .op       (op_e'(in_op)),
        .is32     (in_is32),
        .imm      (in_imm),
        .shift    (in_shift),
        .dst_preg (in_dst_preg),
        .res      (rw_res),
        .kind     (rw_kind)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tbl   = merged;
        st_d.o.vld = in_valid;
        if (in_valid) begin
            st_d.tbl[in_dst] = rw_res;
            st_d.o.kind      = rw_kind;
            st_d.o.dst       = in_dst_preg;
            st_d.o.base      = rw_res.base;
            st_d.o.scale     = rw_res.scale;
            st_d.o.off       = rw_res.off;
            st_d.o.w32       = rw_res.w32;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.o.vld;
    assign out_kind     = st_q.o.kind;
    assign out_dst_preg = st_q.o.dst;
    assign out_base     = st_q.o.base;
    assign out_scale    = st_q.o.scale;
    assign out_offset   = st_q.o.off;
    assign out_w32      = st_q.o.w32;

endmodule

// File: rtl/symrt_core_chk.sv
module symrt_core_chk
    import sym_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [2:0]            in_op,
    input logic                  in_is32,
    input logic [SYM_OFF_W-1:0]  in_imm,
    input logic [SYM_PREG_W-1:0] in_dst_preg,
    input logic                  out_valid,
    input logic [1:0]            out_kind,
    input logic [SYM_PREG_W-1:0] out_dst_preg,
    input logic [SYM_PREG_W-1:0] out_base,
    input logic [1:0]            out_scale,
    input logic [SYM_OFF_W-1:0]  out_offset
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10

    AST_DST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dst_preg == $past(in_dst_preg))); // R10

    AST_SCALE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_scale != 2'd1)); // R5

    AST_PLAIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd0) |->
            (out_base == out_dst_preg && out_scale == 2'd0 && out_offset == '0)); // R6

    AST_OTHER_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b11) |=> (out_kind == 2'd0)); // R6

    AST_LDI_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5) |=>
            (out_kind == 2'd2 &&
             out_offset == ($past(in_is32) ? sext32($past(in_imm)) : $past(in_imm)))); // R2

endmodule

bind symrt_core symrt_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_is32      (in_is32),
    .in_imm       (in_imm),
    .in_dst_preg  (in_dst_preg),
    .out_valid    (out_valid),
    .out_kind     (out_kind),
    .out_dst_preg (out_dst_preg),
    .out_base     (out_base),
    .out_scale    (out_scale),
    .out_offset   (out_offset)
);

// File: tb/symrt_core_test.sv
`timescale 1ns/1ps
module symrt_core_test;

    localparam int AW = 3;
    localparam int PW = 6;
    localparam logic [1:0] KP = 2'd0, KS = 2'd1, KC = 2'd2;
    localparam logic [2:0] MOV = 3'd0, ADDI = 3'd1, ADD = 3'd2, SUB = 3'd3,
                           SADD = 3'd4, LDI = 3'd5, OTH = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic          in_is32 = 1'b0;
    logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic [63:0]   in_imm = '0;
    logic [1:0]    in_shift = '0;
    logic [PW-1:0] in_dst_preg = '0;
    logic          fb_valid = 1'b0;
    logic [PW-1:0] fb_preg = '0;
    logic [63:0]   fb_value = '0;
    logic          out_valid;
    logic [1:0]    out_kind;
    logic [PW-1:0] out_dst_preg, out_base;
    logic [1:0]    out_scale;
    logic [63:0]   out_offset;
    logic          out_w32;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    symrt_core uut (.*);

    task automatic note_fail(input string msg);
        fails++;
        $display("FAIL %s", msg);
    endtask

    // drive one instruction on a falling edge, read its result one cycle later
    task automatic ins(input logic [2:0] op, input logic w, input int a, input int b,
                       input logic [63:0] imm, input logic [1:0] sh, input int d, input int preg);
        in_valid = 1'b1; in_op = op; in_is32 = w;
        in_src_a = AW'(a); in_src_b = AW'(b); in_imm = imm; in_shift = sh;
        in_dst = AW'(d); in_dst_preg = PW'(preg);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; fb_valid = 1'b0;
    endtask

    task automatic fbk(input int p, input logic [63:0] v);
        fb_valid = 1'b1; fb_preg = PW'(p); fb_value = v;
        @(posedge clk); @(negedge clk);
        fb_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [1:0] k, input int base, input int sc,
                       input logic [63:0] off, input int preg);
        logic ok;
        checks++;
        ok = out_valid && out_kind == k && out_offset == off && out_dst_preg == PW'(preg);
        if (k != KC) ok = ok && out_base == PW'(base) && out_scale == 2'(sc);
        if (!ok)
            note_fail($sformatf("%s: got v=%0b kind=%0d base=%0d scale=%0d off=%h dst=%0d, exp kind=%0d base=%0d scale=%0d off=%h dst=%0d",
                tag, out_valid, out_kind, out_base, out_scale, out_offset, out_dst_preg,
                k, base, sc, off, preg));
    endtask

    task automatic chk_w32(input string tag, input logic exp);
        checks++;
        if (out_w32 !== exp) note_fail($sformatf("%s: w32 got %0b exp %0b", tag, out_w32, exp));
    endtask

    task automatic chk_idle(input string tag);
        checks++;
        if (out_valid !== 1'b0) note_fail($sformatf("%s: out_valid got %0b exp 0", tag, out_valid));
    endtask

    task automatic t_reset();
        chk_idle("R1 reset idle");
        ins(MOV, 0, 2, 0, 0, 0, 5, 32); chk("R1 R4 initial map of r2", KS, 2, 0, 0, 32);
    endtask

    task automatic t_const();
        ins(LDI, 0, 0, 0, 64'd3, 0, 1, 33);  chk("R2 load-immediate", KC, 0, 0, 64'd3, 33);
        ins(ADDI, 0, 1, 0, 64'd4, 0, 2, 34); chk("R2 add-imm known", KC, 0, 0, 64'd7, 34);
        ins(ADD, 0, 1, 2, 0, 0, 0, 35);      chk("R2 add known", KC, 0, 0, 64'd10, 35);
    endtask

    task automatic t_reassoc();
        ins(ADDI, 0, 3, 0, 64'd10, 0, 4, 36); chk("R3 add-imm on unknown", KS, 3, 0, 64'd10, 36);
        ins(ADDI, 0, 4, 0, 64'd5, 0, 6, 37);  chk("R3 chained flatten", KS, 3, 0, 64'd15, 37);
        ins(SUB, 0, 6, 1, 0, 0, 7, 38);       chk("R3 sub known subtrahend", KS, 3, 0, 64'd12, 38);
        ins(ADD, 0, 0, 7, 0, 0, 4, 39);       chk("R3 add known first", KS, 3, 0, 64'd22, 39);
    endtask

    task automatic t_plain();
        ins(SUB, 0, 1, 7, 0, 0, 5, 40); chk("R6 sub unknown subtrahend", KP, 40, 0, 0, 40);
        ins(ADD, 0, 6, 7, 0, 0, 5, 41); chk("R6 add both unknown", KP, 41, 0, 0, 41);
        ins(OTH, 0, 1, 2, 0, 0, 5, 42); chk("R6 other op", KP, 42, 0, 0, 42);
    endtask

    task automatic t_scaled();
        ins(SADD, 0, 5, 1, 0, 2, 6, 43); chk("R5 scale from zero", KS, 42, 2, 64'd3, 43);
        ins(SADD, 0, 6, 1, 0, 3, 7, 44); chk("R5 scale overflow", KP, 44, 0, 0, 44);
        ins(SADD, 0, 1, 0, 0, 1, 7, 45); chk("R5 illegal shift", KP, 45, 0, 0, 45);
        ins(SADD, 0, 1, 6, 0, 3, 3, 46); chk("R5 known first operand", KS, 42, 2, 64'd27, 46);
        ins(SADD, 0, 1, 0, 0, 2, 7, 47); chk("R2 R5 scaled add known", KC, 0, 0, 64'd22, 47);
    endtask

    task automatic t_feedback();
        fbk(42, 64'd5);
        chk_idle("R10 idle after feedback only");
        ins(MOV, 0, 6, 0, 0, 0, 0, 48); chk("R8 scaled entry resolved", KC, 0, 0, 64'd23, 48);
        ins(MOV, 0, 3, 0, 0, 0, 0, 49); chk("R8 second entry resolved", KC, 0, 0, 64'd47, 49);
        ins(MOV, 0, 5, 0, 0, 0, 0, 50); chk("R8 plain entry resolved", KC, 0, 0, 64'd5, 50);
        ins(MOV, 0, 4, 0, 0, 0, 0, 51); chk("R8 other base untouched", KS, 3, 0, 64'd22, 51);
        fb_valid = 1'b1; fb_preg = PW'(3); fb_value = 64'd100;
        ins(ADDI, 0, 4, 0, 64'd1, 0, 1, 52); chk("R9 same-cycle feedback", KC, 0, 0, 64'd123, 52);
        ins(MOV, 0, 0, 0, 0, 0, 2, 53); chk("R9 R8 copy also resolved", KC, 0, 0, 64'd122, 53);
    endtask

    task automatic t_w32();
        ins(LDI, 1, 0, 0, 64'h8000_0000, 0, 1, 54);
        chk("R7 load-imm sign extend", KC, 0, 0, 64'hFFFF_FFFF_8000_0000, 54);
        ins(LDI, 0, 0, 0, 64'h7FFF_FFFF, 0, 2, 55);
        chk("R2 64-bit load-imm", KC, 0, 0, 64'h7FFF_FFFF, 55);
        ins(ADDI, 1, 2, 0, 64'd1, 0, 2, 56);
        chk("R7 32-bit add wraps", KC, 0, 0, 64'hFFFF_FFFF_8000_0000, 56);
        ins(OTH, 0, 0, 0, 0, 0, 3, 57); chk("R6 fresh unknown", KP, 57, 0, 0, 57);
        ins(ADDI, 1, 3, 0, 64'h1_8000_0000, 0, 4, 58);
        chk("R7 32-bit symbolic offset", KS, 57, 0, 64'hFFFF_FFFF_8000_0000, 58);
        chk_w32("R7 entry flagged 32-bit", 1'b1);
        ins(MOV, 0, 4, 0, 0, 0, 5, 59); chk("R7 64-bit read of 32-bit entry", KP, 59, 0, 0, 59);
        ins(MOV, 1, 4, 0, 0, 0, 6, 60);
        chk("R7 R4 32-bit copy", KS, 57, 0, 64'hFFFF_FFFF_8000_0000, 60);
        fbk(57, 64'h1_0000_0000);
        ins(MOV, 0, 6, 0, 0, 0, 0, 61);
        chk("R8 R7 32-bit entry resolved", KC, 0, 0, 64'hFFFF_FFFF_8000_0000, 61);
        ins(MOV, 0, 3, 0, 0, 0, 0, 62);
        chk("R8 64-bit entry resolved", KC, 0, 0, 64'h1_0000_0000, 62);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_const();
        t_reassoc();
        t_plain();
        t_scaled();
        t_feedback();
        t_w32();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        note_fail("R10 watchdog expired: got hang exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule